// File: doc/BRIEF.md
# SPI Memory Card Initialization Sequencer

This block sits on the host side of a memory card that runs in SPI mode and takes it from reset to ready. A pulse on `start` makes it send the software reset command (index 0). It then sends the operating-condition command (index 1) again and again until the first response byte shows that the card has left its idle state. Once the card is ready, or at any other time the sequencer is free, a pulse on `ocrReq` sends the read-OCR command (index 58) and captures the 32-bit register that follows the response byte.

The block drives a byte-level SPI shifter. It asks for one byte exchange at a time with `xferStart` and `txByte`, and the shifter answers with `xferDone` and the received `rxByte`. The block also drives chip select and a clock enable. Every transaction ends the same way: chip select is released, one all-ones filler byte supplies eight more clocks, and only then is the clock enable dropped. Any failure is reported only after these trailing clocks. The poll limit and the response window are parameters.

Top module: `spi_card_init`

## Requirements
- R1: After reset, `csN` is 1 and `clkEn`, `busy`, `done`, `fail` and `ocrDone` are all 0.
- R2: Every command goes out as 6 bytes while `csN` is 0. Byte 0 is 0x40 OR the command index. Bytes 1 to 4 are 0x00. Byte 5 is the CRC7 of the first 40 bits followed by an end bit of 1, which gives 0x95 for index 0, 0xF9 for index 1 and 0xFD for index 58.
- R3: After `start`, index 0 is sent first and every later command of the run is index 1. An `ocrReq` that arrives while `busy` is 1 is ignored and never produces an index 58 command.
- R4: The response byte is bit 0 of R1, the in-idle flag. When an index 1 response has this bit at 0, `done` pulses for one cycle and `fail` stays 0. The number of index 1 commands sent equals the number of idle responses the card gave plus one.
- R5: The response is the first received byte with bit 7 equal to 0, searched over at most 8 filler bytes (0xFF) after the frame. If no such byte arrives, `fail` pulses with `errCode` 1.
- R6: In a response byte, bit 2 marks an illegal command and bit 3 marks a CRC error. Either one aborts the run with `fail`, with `errCode` 2 for illegal and 3 for CRC. When both bits are set, 2 is reported.
- R7: If the card is still idle after MAX_POLLS index 1 commands, `fail` pulses with `errCode` 4 and no further command is sent.
- R8: After each transaction, `csN` goes to 1 and exactly one 0xFF byte is exchanged before the next frame or before `clkEn` falls. Any outcome pulse comes after that byte, and `clkEn` only ever falls while `csN` is 1.
- R9: An `ocrReq` pulse while idle sends index 58. The 4 bytes after its response byte are placed MSB first on `ocrValue`, and then `ocrDone` pulses.
- R10: `clkEn` is 1 whenever a byte exchange is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts an initialization run (taken only while idle) |
| ocrReq | input | 1 | Requests an OCR read (taken only while idle) |
| busy | output | 1 | A run or an OCR read is in progress |
| done | output | 1 | One-cycle pulse: the card is ready |
| fail | output | 1 | One-cycle pulse: the run was aborted |
| errCode | output | 3 | Reason for the last abort |
| ocrDone | output | 1 | One-cycle pulse: `ocrValue` has been updated |
| ocrValue | output | 32 | Last OCR value read |
| xferStart | output | 1 | Asks the shifter to exchange one byte |
| txByte | output | 8 | Byte to transmit |
| xferDone | input | 1 | Pulse from the shifter: the exchange has finished |
| rxByte | input | 8 | Byte received in that exchange |
| csN | output | 1 | Chip select to the card, active low |
| clkEn | output | 1 | Lets the shifter run the SPI clock |

## Verification
The bench models the card byte by byte. It varies the number of idle replies, the delay before the response and which command carries an injected error flag. Two cases sit on the edges of their limits. A response on the eighth filler byte must still be accepted; a design whose window is one byte short would report a response timeout there instead. A card that becomes ready exactly on the last allowed poll must give `done`; a design that compares the poll count off by one would report an init timeout there, or send one command too many. Other cases catch a missing or doubled trailing byte, an error reported before the trailing clocks, the wrong error chosen when both flags are set, and a read-OCR command sent in the middle of a run because an `ocrReq` arrived while busy.

// File: rtl/spi_init_pkg.sv
package spi_init_pkg;

  typedef enum logic [1:0] {
    CMD_RESET  = 2'd0,
    CMD_OPCOND = 2'd1,
    CMD_RDOCR  = 2'd2
  } cmdSel_t;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_RESP_TMO = 3'd1,
    ERR_ILLEGAL  = 3'd2,
    ERR_CRC      = 3'd3,
    ERR_INIT_TMO = 3'd4
  } errCode_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic    loadCmd;
    cmdSel_t cmdSel;
    logic    cmdPhase;
    logic    cntInc;
    logic    cntClr;
    logic    pollInc;
    logic    pollClr;
    logic    idleCap;
    logic    ocrCap;
  } dpStrobe_t;

  function automatic logic [5:0] cmdIndex(input cmdSel_t sel);
    case (sel)
      CMD_RESET:  return 6'd0;
      CMD_OPCOND: return 6'd1;
      default:    return 6'd58;
    endcase
  endfunction

  // CRC7, polynomial x^7 + x^3 + 1, MSB first
  function automatic logic [6:0] crc7(input logic [39:0] data);
    logic [6:0] acc;
    logic       fb;
    acc = '0;
    for (int i = 39; i >= 0; i--) begin
      fb  = data[i] ^ acc[6];
      acc = {acc[5:0], 1'b0};
      if (fb) acc = acc ^ 7'h09;
    end
    return acc;
  endfunction

endpackage

// File: rtl/spi_init_dp.sv
module spi_init_dp
  import spi_init_pkg::*;
#(
  parameter int RESP_BYTES = 8,
  parameter int MAX_POLLS  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strb,
  input  logic [7:0]  rxByte,
  output logic [7:0]  txByte,
  output logic        frameLast,
  output logic        respLast,
  output logic        ocrLast,
  output logic        pollHit,
  output logic        cardIdle,
  output logic [31:0] ocrWord
);

  localparam int CNT_SPAN  = (RESP_BYTES > 6) ? RESP_BYTES : 6;
  localparam int CNT_W     = $clog2(CNT_SPAN);
  localparam int POLL_W    = $clog2(MAX_POLLS + 1);
  localparam int FRAME_LEN = 6;
  localparam int OCR_LEN   = 4;

  logic [CNT_W-1:0]  cnt;
  logic [POLL_W-1:0] pollCnt;
  logic [5:0]        cmdIdx;
  logic              idleQ;
  logic [31:0]       ocrQ;
  logic [39:0]       frameHead;
  logic [47:0]       frameWord;
  logic [47:0]       frameSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      pollCnt <= '0;
      cmdIdx  <= '0;
      idleQ   <= 1'b1;
      ocrQ    <= '0;
    end else begin
      if (strb.cntClr)       cnt <= '0;
      else if (strb.cntInc)  cnt <= cnt + 1'b1;
      if (strb.pollClr)      pollCnt <= '0;
      else if (strb.pollInc) pollCnt <= pollCnt + 1'b1;
      if (strb.loadCmd)      cmdIdx <= cmdIndex(strb.cmdSel);
      if (strb.idleCap)      idleQ <= rxByte[0];
      if (strb.ocrCap)       ocrQ <= {ocrQ[23:0], rxByte};
    end
  end

  always_comb begin
    frameHead = {2'b01, cmdIdx, 32'h0000_0000};
    frameWord = {frameHead, crc7(frameHead), 1'b1};
    frameSh   = frameWord << {cnt, 3'b000};
    txByte    = strb.cmdPhase ? frameSh[47:40] : 8'hFF;
  end

  assign frameLast = (cnt == CNT_W'(FRAME_LEN - 1));
  assign respLast  = (cnt == CNT_W'(RESP_BYTES - 1));
  assign ocrLast   = (cnt == CNT_W'(OCR_LEN - 1));
  assign pollHit   = (pollCnt == POLL_W'(MAX_POLLS));
  assign cardIdle  = idleQ;
  assign ocrWord   = ocrQ;

  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdPhase && strb.cntInc) |-> (cnt < CNT_W'(FRAME_LEN - 1))) // R2
    else $error("frame byte counter ran past the last frame byte");

endmodule

// File: rtl/spi_init_ctrl.sv
module spi_init_ctrl
  import spi_init_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      ocrReq,
  input  logic      xferDone,
  input  logic      rxZeroMsb,
  input  logic      rxIllegal,
  input  logic      rxCrcErr,
  input  logic      frameLast,
  input  logic      respLast,
  input  logic      ocrLast,
  input  logic      pollHit,
  input  logic      cardIdle,
  output dpStrobe_t strb,
  output logic      xferStart,
  output logic      csN,
  output logic      clkEn,
  output logic      busy,
  output logic      done,
  output logic      fail,
  output logic      ocrDone,
  output errCode_t  errCode
);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD_GO, S_CMD_WT, S_RSP_GO, S_RSP_WT,
    S_OCR_GO, S_OCR_WT, S_TRL_GO, S_TRL_WT
  } state_t;

  state_t   state, stateNext;
  cmdSel_t  cmdCur, cmdNext;
  errCode_t errPend, errPendNext, errCodeNext;
  logic     doneNext, failNext, ocrDoneNext;

  always_comb begin
    stateNext   = state;
    cmdNext     = cmdCur;
    errPendNext = errPend;
    errCodeNext = errCode;
    doneNext    = 1'b0;
    failNext    = 1'b0;
    ocrDoneNext = 1'b0;
    strb        = '0;
    xferStart   = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strb.loadCmd = 1'b1;
          strb.cmdSel  = CMD_RESET;
          strb.cntClr  = 1'b1;
          strb.pollClr = 1'b1;
          cmdNext      = CMD_RESET;
          errPendNext  = ERR_NONE;
          stateNext    = S_CMD_GO;
        end else if (ocrReq) begin
          strb.loadCmd = 1'b1;
          strb.cmdSel  = CMD_RDOCR;
          strb.cntClr  = 1'b1;
          cmdNext      = CMD_RDOCR;
          errPendNext  = ERR_NONE;
          stateNext    = S_CMD_GO;
        end
      end
      S_CMD_GO: begin
        strb.cmdPhase = 1'b1;
        xferStart     = 1'b1;
        stateNext     = S_CMD_WT;
      end
      S_CMD_WT: begin
        strb.cmdPhase = 1'b1;
        if (xferDone) begin
          if (frameLast) begin
            strb.cntClr = 1'b1;
            stateNext   = S_RSP_GO;
          end else begin
            strb.cntInc = 1'b1;
            stateNext   = S_CMD_GO;
          end
        end
      end
      S_RSP_GO: begin
        xferStart = 1'b1;
        stateNext = S_RSP_WT;
      end
      S_RSP_WT: begin
        if (xferDone) begin
          if (rxZeroMsb) begin
            strb.idleCap = 1'b1;
            strb.cntClr  = 1'b1;
            if (rxIllegal)     errPendNext = ERR_ILLEGAL;
            else if (rxCrcErr) errPendNext = ERR_CRC;
            stateNext = (!rxIllegal && !rxCrcErr && cmdCur == CMD_RDOCR) ? S_OCR_GO : S_TRL_GO;
          end else if (respLast) begin
            errPendNext = ERR_RESP_TMO;
            stateNext   = S_TRL_GO;
          end else begin
            strb.cntInc = 1'b1;
            stateNext   = S_RSP_GO;
          end
        end
      end
      S_OCR_GO: begin
        xferStart = 1'b1;
        stateNext = S_OCR_WT;
      end
      S_OCR_WT: begin
        if (xferDone) begin
          strb.ocrCap = 1'b1;
          if (ocrLast) begin
            stateNext = S_TRL_GO;
          end else begin
            strb.cntInc = 1'b1;
            stateNext   = S_OCR_GO;
          end
        end
      end
      S_TRL_GO: begin
        xferStart = 1'b1;
        stateNext = S_TRL_WT;
      end
      S_TRL_WT: begin
        if (xferDone) begin
          stateNext = S_IDLE;
          if (errPend != ERR_NONE) begin
            failNext    = 1'b1;
            errCodeNext = errPend;
          end else if (cmdCur == CMD_RDOCR) begin
            ocrDoneNext = 1'b1;
          end else if (cmdCur == CMD_OPCOND && !cardIdle) begin
            doneNext = 1'b1;
          end else if (cmdCur == CMD_OPCOND && pollHit) begin
            failNext    = 1'b1;
            errCodeNext = ERR_INIT_TMO;
          end else begin
            strb.loadCmd = 1'b1;
            strb.cmdSel  = CMD_OPCOND;
            strb.cntClr  = 1'b1;
            strb.pollInc = 1'b1;
            cmdNext      = CMD_OPCOND;
            stateNext    = S_CMD_GO;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cmdCur  <= CMD_RESET;
      errPend <= ERR_NONE;
      errCode <= ERR_NONE;
      done    <= 1'b0;
      fail    <= 1'b0;
      ocrDone <= 1'b0;
    end else begin
      state   <= stateNext;
      cmdCur  <= cmdNext;
      errPend <= errPendNext;
      errCode <= errCodeNext;
      done    <= doneNext;
      fail    <= failNext;
      ocrDone <= ocrDoneNext;
    end
  end

  assign busy  = (state != S_IDLE);
  assign clkEn = busy;
  assign csN   = !(state inside {S_CMD_GO, S_CMD_WT, S_RSP_GO, S_RSP_WT, S_OCR_GO, S_OCR_WT});

  AST_START_CLK: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> clkEn) // R10
    else $error("byte exchange started with the clock gated");
  AST_CLK_STOP_CS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkEn) |-> csN) // R8
    else $error("clock stopped while chip select was asserted");
  AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.pollInc |-> !pollHit) // R7
    else $error("poll command issued beyond the limit");
  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail)) // R4
    else $error("done and fail pulsed together");
  AST_FAIL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (errCode != ERR_NONE)) // R6
    else $error("fail pulsed without an error code");

endmodule

// File: rtl/spi_card_init.sv
module spi_card_init
  import spi_init_pkg::*;
#(
  parameter int RESP_BYTES = 8,
  parameter int MAX_POLLS  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        ocrReq,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic [2:0]  errCode,
  output logic        ocrDone,
  output logic [31:0] ocrValue,
  output logic        xferStart,
  output logic [7:0]  txByte,
  input  logic        xferDone,
  input  logic [7:0]  rxByte,
  output logic        csN,
  output logic        clkEn
);

  dpStrobe_t strb;
  errCode_t  errCodeQ;
  logic      frameLast, respLast, ocrLast, pollHit, cardIdle;

  spi_init_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .ocrReq    (ocrReq),
    .xferDone  (xferDone),
    .rxZeroMsb (!rxByte[7]),
    .rxIllegal (rxByte[2]),
    .rxCrcErr  (rxByte[3]),
    .frameLast (frameLast),
    .respLast  (respLast),
    .ocrLast   (ocrLast),
    .pollHit   (pollHit),
    .cardIdle  (cardIdle),
    .strb      (strb),
    .xferStart (xferStart),
    .csN       (csN),
    .clkEn     (clkEn),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .ocrDone   (ocrDone),
    .errCode   (errCodeQ)
  );

  spi_init_dp #(
    .RESP_BYTES (RESP_BYTES),
    .MAX_POLLS  (MAX_POLLS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rxByte    (rxByte),
    .txByte    (txByte),
    .frameLast (frameLast),
    .respLast  (respLast),
    .ocrLast   (ocrLast),
    .pollHit   (pollHit),
    .cardIdle  (cardIdle),
    .ocrWord   (ocrValue)
  );

  assign errCode = errCodeQ;

endmodule

// File: tb/spi_card_init_tb_top.sv
module spi_card_init_tb_top;

  localparam int MAXP = 5;
  localparam int NVEC = 8;
  // {idleReplies[31:24], respDelay[23:20], illegalIdx[19:14], crcIdx[13:8], expErr[7:5], expCmd1[4:0]}; index 63 = no injection
  localparam logic [31:0] VECS [NVEC] = '{
    {8'd0, 4'd0, 6'd63, 6'd63, 3'd0, 5'd1},
    {8'd3, 4'd2, 6'd63, 6'd63, 3'd0, 5'd4},
    {8'd4, 4'd7, 6'd63, 6'd63, 3'd0, 5'd5},
    {8'd5, 4'd1, 6'd63, 6'd63, 3'd4, 5'd5},
    {8'd2, 4'd8, 6'd63, 6'd63, 3'd1, 5'd0},
    {8'd0, 4'd1, 6'd1,  6'd63, 3'd2, 5'd1},
    {8'd1, 4'd0, 6'd63, 6'd0,  3'd3, 5'd0},
    {8'd1, 4'd3, 6'd1,  6'd1,  3'd2, 5'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, ocrReq = 1'b0;
  logic busy, done, fail, ocrDone, xferStart, csN, clkEn;
  logic [2:0] errCode;
  logic [31:0] ocrValue;
  logic [7:0] txByte;
  logic xferDone = 1'b0;
  logic [7:0] rxByte = 8'hFF;

  always #10 clk = ~clk;

  spi_card_init #(.RESP_BYTES(8), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .ocrReq(ocrReq),
    .busy(busy), .done(done), .fail(fail), .errCode(errCode),
    .ocrDone(ocrDone), .ocrValue(ocrValue),
    .xferStart(xferStart), .txByte(txByte), .xferDone(xferDone), .rxByte(rxByte),
    .csN(csN), .clkEn(clkEn)
  );

  int nChecks = 0, nFail = 0, cycles = 0;
  // card model state
  int idleLeft, respDelay, injIll, injCrc, replyIdx, frameCnt;
  int cmdLogN, trailBytes, trailBad, frameBad, clkBad, cmd1Cnt, orderBad;
  logic cardIdle, haveCmd;
  logic [7:0] cmdBuf [6];
  logic [7:0] r1Cur;
  logic [5:0] lastIdx;
  logic [31:0] cardOcr;
  logic sawDone, sawFail;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cardReset(input int idl, input int dly, input int ill, input int crc);
    idleLeft = idl; respDelay = dly; injIll = ill; injCrc = crc;
    replyIdx = 0; frameCnt = 0; cmdLogN = 0; trailBytes = 0; trailBad = 0;
    frameBad = 0; clkBad = 0; cmd1Cnt = 0; orderBad = 0;
    cardIdle = 1'b1; haveCmd = 1'b0; r1Cur = 8'hFF; lastIdx = '0;
  endtask

  task automatic cardByte(input logic [7:0] tx, input logic cs, output logic [7:0] rx);
    logic [7:0] expCrc, flags;
    int k;
    rx = 8'hFF;
    if (cs) begin
      trailBytes++;
      if (tx != 8'hFF) trailBad++;
      haveCmd = 1'b0; frameCnt = 0;
    end else if (!haveCmd) begin
      if (frameCnt == 0 && trailBytes != cmdLogN) trailBad++;
      cmdBuf[frameCnt] = tx;
      frameCnt++;
      if (frameCnt == 6) begin
        haveCmd = 1'b1; replyIdx = 0;
        lastIdx = cmdBuf[0][5:0];
        if (cmdBuf[0][7:6] != 2'b01 || {cmdBuf[1], cmdBuf[2], cmdBuf[3], cmdBuf[4]} != 32'h0) frameBad++;
        expCrc = (lastIdx == 6'd0) ? 8'h95 : (lastIdx == 6'd1) ? 8'hF9 : (lastIdx == 6'd58) ? 8'hFD : 8'h00;
        if (cmdBuf[5] != expCrc) frameBad++;
        if ((cmdLogN == 0 && lastIdx != 6'd0) || (cmdLogN > 0 && lastIdx != 6'd1)) orderBad++;
        cmdLogN++;
        flags = ((int'(lastIdx) == injIll) ? 8'h04 : 8'h00) | ((int'(lastIdx) == injCrc) ? 8'h08 : 8'h00);
        if (lastIdx == 6'd0) begin
          cardIdle = 1'b1; r1Cur = 8'h01 | flags;
        end else if (lastIdx == 6'd1) begin
          cmd1Cnt++;
          if (idleLeft > 0) begin idleLeft--; r1Cur = 8'h01 | flags; end
          else begin cardIdle = 1'b0; r1Cur = 8'h00 | flags; end
        end else begin
          r1Cur = {7'd0, cardIdle} | flags;
        end
      end
    end else begin
      k = replyIdx - respDelay;
      if (k == 0) rx = r1Cur;
      else if (k >= 1 && k <= 4 && lastIdx == 6'd58) rx = 8'(cardOcr >> (8 * (4 - k)));
      replyIdx++;
    end
  endtask

  task automatic waitOutcome(input int limit);
    sawDone = 1'b0; sawFail = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done) sawDone = 1'b1;
      if (fail) sawFail = 1'b1;
      if (done || fail || ocrDone) break;
    end
  endtask

  initial begin
    cardReset(0, 0, 63, 63);
    cardOcr = 32'h0;
    fork
      begin : shifter
        logic [7:0] rxv;
        forever begin
          @(negedge clk);
          xferDone = 1'b0;
          if (xferStart) begin
            if (!clkEn) clkBad++;
            cardByte(txByte, csN, rxv);
            @(negedge clk);
            @(negedge clk);
            rxByte = rxv;
            xferDone = 1'b1;
          end
        end
      end
      begin : watchdog
        wait (cycles > 150000);
        nFail++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 csN", csN, 1); chk("R1 clkEn", clkEn, 0); chk("R1 busy", busy, 0);
    chk("R1 done/fail/ocrDone", {done, fail, ocrDone}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] vec;
      logic pressOcr;
      int cnt0;
      vec = VECS[v];
      pressOcr = (v == 1);
      cardReset(int'(vec[31:24]), int'(vec[23:20]), int'(vec[19:14]), int'(vec[13:8]));
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      sawDone = 1'b0; sawFail = 1'b0;
      for (int i = 0; i < 20000; i++) begin
        ocrReq = pressOcr && busy && cmdLogN >= 1 && cmdLogN < 3;
        @(negedge clk);
        if (done) sawDone = 1'b1;
        if (fail) sawFail = 1'b1;
        if (done || fail) break;
      end
      ocrReq = 1'b0;
      // R4 / R5 / R6 / R7 outcome
      chk($sformatf("R4 R5 R6 R7 vec%0d outcome", v), {sawDone, sawFail}, (vec[7:5] == 3'd0) ? 2'b10 : 2'b01);
      if (vec[7:5] != 3'd0) chk($sformatf("R5 R6 R7 vec%0d errCode", v), errCode, vec[7:5]);
      chk($sformatf("R4 R7 vec%0d cmd1 count", v), cmd1Cnt, vec[4:0]);
      chk($sformatf("R2 vec%0d frame bytes", v), frameBad, 0);
      chk($sformatf("R3 vec%0d command order", v), orderBad, 0);
      chk($sformatf("R8 vec%0d trail before outcome", v), trailBytes, cmdLogN);
      chk($sformatf("R10 vec%0d clock at start", v), clkBad, 0);
      cnt0 = cmdLogN;
      repeat (20) @(negedge clk);
      chk($sformatf("R8 vec%0d idle pins", v), {csN, clkEn, busy}, 3'b100);
      chk($sformatf("R8 vec%0d trail bytes", v), {trailBad, trailBytes}, {32'd0, cmdLogN});
      chk($sformatf("R3 vec%0d no late command", v), cmdLogN, cnt0);
    end

    // R9: OCR read after a successful init (card now ready)
    cardReset(0, 0, 63, 63);
    start = 1'b1; @(negedge clk); start = 1'b0;
    waitOutcome(20000);
    chk("R4 init before OCR", sawDone, 1);
    cardReset(0, 3, 63, 63);
    cardIdle = 1'b0;
    cardOcr = 32'h80FF_8000;
    ocrReq = 1'b1; @(negedge clk); ocrReq = 1'b0;
    waitOutcome(20000);
    chk("R9 ocrDone", ocrDone, 1);
    chk("R9 ocrValue", ocrValue, 32'h80FF_8000);
    chk("R9 command index", {cmdLogN, 26'd0, lastIdx}, {32'd1, 32'd58});
    chk("R2 read-OCR frame", frameBad, 0);
    chk("R8 read-OCR trail", {trailBad, trailBytes}, {32'd0, 32'd1});

    // R9 with a different value and an immediate response
    cardReset(0, 0, 63, 63);
    cardIdle = 1'b0;
    cardOcr = 32'hC0FF_8012;
    ocrReq = 1'b1; @(negedge clk); ocrReq = 1'b0;
    waitOutcome(20000);
    chk("R9 ocrValue second", ocrValue, 32'hC0FF_8012);

    // R1 again after a mid-run reset
    cardReset(3, 0, 63, 63);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset", {csN, clkEn, busy, done, fail, ocrDone}, 6'b100000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule